// File: doc/BRIEF.md
# Double-Buffered Input Gamma Lookup Table

This block maps each colour channel of an incoming pixel through a per-channel lookup table before the rest of the colour pipeline sees it. It holds two complete table banks, so software can fill one bank while the pixel path keeps reading the other, and then swap them without a visible tear. Each bank has 256 entries for each of red, green and blue. Each entry is a 12-bit unsigned fraction with no integer part.

The host loads a bank through a small set of register-style controls. It picks a target bank and sets a starting index. It then writes colour words, which land on red, green and blue in turn, and the index steps forward after every blue word. A per-channel enable mask and a memory power-enable bit gate these writes. The host asks for a lookup mode. The block applies that mode at the next frame-start strobe and reports a status code that combines the active bank with the degamma ROM selection from elsewhere in the pipe.

Top module: `igam_dual_bank_lut`

## Requirements
- R1: After a synchronous active-low reset, `out_vld` is 0, all three pixel outputs are 0, the applied mode is pass-through and `status` is 0.
- R2: In mode 0 (pass-through), each output is the 8-bit table index extended to 12 bits by bit replication: {v[7:0], v[7:4]}.
- R3: A 10-bit pixel input is truncated to its upper 8 bits, [9:2], to form the table index. The two low bits have no effect on the result.
- R4: Each data write stores to red, then green, then blue at the current index, and the index advances by one (wrapping 255 to 0) after blue. An index write sets the index and restarts the rotation at red. An index write takes priority over a data write in the same cycle.
- R5: `wr_mask` bit 0 enables red, bit 1 green and bit 2 blue. A write to a masked channel stores nothing, but the rotation and index still advance.
- R6: A data write while `mem_pwr_en` is 0 stores nothing and does not advance the rotation or the index. Index writes are accepted regardless of `mem_pwr_en`.
- R7: `bank_sel` 0 directs data writes to bank A and 1 to bank B.
- R8: Mode 2 reads bank A and mode 3 reads bank B. The looked-up values appear on the outputs one clock after the pixel is presented.
- R9: A new `mode_req` value takes effect only at a cycle with `frame_start` high. Until then the previously applied mode stays in force.
- R10: `status` reports 0 in pass-through. With bank A active it reports 1, 3 or 4, and with bank B active it reports 2, 5 or 6, for `dgam_sel` = 0 (no ROM), 1 (ROM A) or 2 (ROM B). A `dgam_sel` of 3 reads as no ROM.
- R11: `out_vld` equals `pix_vld` delayed by one clock. Mode 1 behaves as pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_sel | input | 1 | Target bank for data writes (0 = A, 1 = B) |
| idx_wr | input | 1 | Strobe: load write index |
| idx_val | input | 8 | Index value to load |
| data_wr | input | 1 | Strobe: write one colour word |
| data_val | input | 12 | Colour word, u0.12 |
| wr_mask | input | 3 | Channel write enables {B,G,R} |
| mem_pwr_en | input | 1 | Table memory power enable; data writes need it high |
| mode_req | input | 2 | Requested lookup mode (0/1 pass, 2 bank A, 3 bank B) |
| dgam_sel | input | 2 | Degamma ROM selection used in status |
| frame_start | input | 1 | Frame boundary strobe; applies `mode_req` |
| status | output | 3 | Combined bank-usage status code |
| pix_vld | input | 1 | Pixel input valid |
| pix_r | input | 10 | Red input |
| pix_g | input | 10 | Green input |
| pix_b | input | 10 | Blue input |
| out_vld | output | 1 | Output valid, one clock after `pix_vld` |
| out_r | output | 12 | Red result |
| out_g | output | 12 | Green result |
| out_b | output | 12 | Blue result |

## Verification
The bench uses the default parameters: 10-bit pixel inputs, an 8-bit index and 12-bit entries. With these values the two dropped low bits of the pixel can be exercised, and so can the bit-replicated pass-through. It also fills both complete 256-entry banks with different computed patterns, so a bank mix-up, an off-by-one in the index or a wrong channel rotation shows up as a numeric mismatch. Because the index is narrow enough to step through every entry, the bench can reach the wrap after blue and the masked, unpowered and same-cycle index cases at chosen entries.

// File: rtl/igam_pkg.sv
// Shared types and the status encoding for the dual-bank input gamma table.
// Assumes three colour channels and two banks.
package igam_pkg;
    localparam int NCH   = 3;
    localparam int NBANK = 2;

    typedef enum logic [1:0] {CH_R = 2'd0, CH_G = 2'd1, CH_B = 2'd2} chan_e;

    localparam logic [1:0] MODE_PASS  = 2'd0;
    localparam logic [1:0] MODE_PASS1 = 2'd1;
    localparam logic [1:0] MODE_BANKA = 2'd2;
    localparam logic [1:0] MODE_BANKB = 2'd3;

    // Combined status: bank in use plus degamma ROM choice.
    function automatic logic [2:0] status_code(input logic [1:0] mode, input logic [1:0] rom);
        logic [2:0] base;
        logic [2:0] val;
        base = (mode == MODE_BANKA) ? 3'd1 : 3'd2;
        case (rom)
            2'd1:    val = (mode == MODE_BANKA) ? 3'd3 : 3'd5;
            2'd2:    val = (mode == MODE_BANKA) ? 3'd4 : 3'd6;
            default: val = base;
        endcase
        if (mode[1] == 1'b0) val = 3'd0;
        return val;
    endfunction
endpackage

// File: rtl/igam_bank_ram.sv
// One channel of one bank: a synchronous single-write, single-read table.
// Assumes the caller holds raddr stable for one cycle to see rdata.
module igam_bank_ram #(
    parameter int IDX_W = 8,
    parameter int OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [OUT_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [OUT_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [OUT_W-1:0] mem [DEPTH];

    // Store one entry on a write enable.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read of the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[raddr];
    end
endmodule

// File: rtl/igam_wr_seq.sv
// Host write sequencer: keeps the write index and the R/G/B rotation and
// decodes the per-bank, per-channel write enables. Assumes one strobe per
// host write; an index write outranks a same-cycle data write.
module igam_wr_seq
    import igam_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int OUT_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   idx_wr,
    input  logic [IDX_W-1:0]       idx_val,
    input  logic                   data_wr,
    input  logic [OUT_W-1:0]       data_val,
    input  logic [NCH-1:0]         wr_mask,
    input  logic                   bank_sel,
    input  logic                   pwr_en,
    output logic [IDX_W-1:0]       wr_addr,
    output logic [OUT_W-1:0]       wr_data,
    output logic [NBANK*NCH-1:0]   wr_en
);
    logic [IDX_W-1:0] idx_q;
    chan_e            ptr_q;
    logic             accept;

    assign accept  = data_wr && pwr_en && !idx_wr;
    assign wr_addr = idx_q;
    assign wr_data = data_val;

    // Advance rotation and index on accepted writes; reload on index writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            ptr_q <= CH_R;
        end else if (idx_wr) begin
            idx_q <= idx_val;
            ptr_q <= CH_R;
        end else if (accept) begin
            if (ptr_q == CH_B) begin
                ptr_q <= CH_R;
                idx_q <= idx_q + 1'b1;
            end else begin
                ptr_q <= chan_e'(ptr_q + 2'd1);
            end
        end
    end

    // Decode the single enable for the selected bank and current channel.
    always_comb begin
        wr_en = '0;
        for (int b = 0; b < NBANK; b++) begin
            for (int c = 0; c < NCH; c++) begin
                if (accept && wr_mask[c] && (int'(bank_sel) == b) && (int'(ptr_q) == c))
                    wr_en[b*NCH+c] = 1'b1;
            end
        end
    end

    a_r4_ptr_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q != 2'd3);
    a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ptr_q == CH_B) |=> (idx_q == $past(idx_q) + 1'b1) && (ptr_q == CH_R));
    a_r6_hold_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !pwr_en && !idx_wr) |=> $stable(idx_q) && $stable(ptr_q));
    a_r4_idx_load: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (idx_q == $past(idx_val)) && (ptr_q == CH_R));
endmodule

// File: rtl/igam_mode_ctl.sv
// Applies the requested lookup mode at frame boundaries and forms status.
// Assumes frame_start is a one-cycle strobe.
module igam_mode_ctl
    import igam_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_req,
    input  logic       frame_start,
    input  logic [1:0] dgam_sel,
    output logic [1:0] active_mode,
    output logic [2:0] status
);
    // Latch the requested mode only at a frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)          active_mode <= MODE_PASS;
        else if (frame_start) active_mode <= mode_req;
    end

    // Report what the pixel path is using right now.
    always_comb status = status_code(active_mode, dgam_sel);

    a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(active_mode));
    a_r9_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> active_mode == $past(mode_req));
    a_r10_status_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mode[1] == 1'b0) |-> (status == 3'd0));
endmodule

// File: rtl/igam_dual_bank_lut.sv
// Top: two-bank per-channel input gamma table. The host fills banks via the
// write sequencer; the pixel path reads the bank chosen by the applied mode
// and returns results one clock after pix_vld. Assumes IN_W >= IDX_W and
// OUT_W - IDX_W <= IDX_W.
module igam_dual_bank_lut
    import igam_pkg::*;
#(
    parameter int IN_W  = 10,
    parameter int IDX_W = 8,
    parameter int OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bank_sel,
    input  logic             idx_wr,
    input  logic [IDX_W-1:0] idx_val,
    input  logic             data_wr,
    input  logic [OUT_W-1:0] data_val,
    input  logic [2:0]       wr_mask,
    input  logic             mem_pwr_en,
    input  logic [1:0]       mode_req,
    input  logic [1:0]       dgam_sel,
    input  logic             frame_start,
    output logic [2:0]       status,
    input  logic             pix_vld,
    input  logic [IN_W-1:0]  pix_r,
    input  logic [IN_W-1:0]  pix_g,
    input  logic [IN_W-1:0]  pix_b,
    output logic             out_vld,
    output logic [OUT_W-1:0] out_r,
    output logic [OUT_W-1:0] out_g,
    output logic [OUT_W-1:0] out_b
);
    localparam int EXT_W = OUT_W - IDX_W;

    logic [IDX_W-1:0]     wr_addr;
    logic [OUT_W-1:0]     wr_data;
    logic [NBANK*NCH-1:0] wr_en;
    logic [1:0]           active_mode;
    logic [1:0]           mode_q;
    logic [IDX_W-1:0]     rd_idx [NCH];
    logic [IDX_W-1:0]     idx_q  [NCH];
    logic [OUT_W-1:0]     rd     [NBANK][NCH];
    logic [OUT_W-1:0]     res    [NCH];

    igam_wr_seq #(.IDX_W(IDX_W), .OUT_W(OUT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_val(idx_val),
        .data_wr(data_wr), .data_val(data_val), .wr_mask(wr_mask),
        .bank_sel(bank_sel), .pwr_en(mem_pwr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en)
    );

    igam_mode_ctl u_mode (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .frame_start(frame_start),
        .dgam_sel(dgam_sel), .active_mode(active_mode), .status(status)
    );

    // Truncate each pixel channel to its upper IDX_W bits.
    always_comb begin
        rd_idx[0] = pix_r[IN_W-1 -: IDX_W];
        rd_idx[1] = pix_g[IN_W-1 -: IDX_W];
        rd_idx[2] = pix_b[IN_W-1 -: IDX_W];
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            igam_bank_ram #(.IDX_W(IDX_W), .OUT_W(OUT_W)) u_ram (
                .clk(clk), .rst_n(rst_n), .we(wr_en[b*NCH+c]),
                .waddr(wr_addr), .wdata(wr_data),
                .raddr(rd_idx[c]), .rdata(rd[b][c])
            );
        end
    end

    // Pipeline stage alongside the table read: valid, mode and raw index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            mode_q  <= MODE_PASS;
            for (int c = 0; c < NCH; c++) idx_q[c] <= '0;
        end else begin
            out_vld <= pix_vld;
            mode_q  <= active_mode;
            for (int c = 0; c < NCH; c++) idx_q[c] <= rd_idx[c];
        end
    end

    // Choose bank A, bank B or the bit-replicated pass-through per channel.
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            case (mode_q)
                MODE_BANKA: res[c] = rd[0][c];
                MODE_BANKB: res[c] = rd[1][c];
                default:    res[c] = {idx_q[c], idx_q[c][IDX_W-1 -: EXT_W]};
            endcase
        end
    end

    assign out_r = res[0];
    assign out_g = res[1];
    assign out_b = res[2];

    a_r11_vld_rise: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |=> out_vld);
    a_r11_vld_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |=> !out_vld);
    a_r10_status_range: assert property (@(posedge clk) disable iff (!rst_n)
        status != 3'd7);
    a_r4_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));
endmodule

// File: tb/sim_igam_dual_bank_lut.sv
module sim_igam_dual_bank_lut;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bank_sel = 1'b0, idx_wr = 1'b0, data_wr = 1'b0, mem_pwr_en = 1'b0;
    logic frame_start = 1'b0, pix_vld = 1'b0;
    logic [7:0]  idx_val = '0;
    logic [11:0] data_val = '0;
    logic [2:0]  wr_mask = 3'd7;
    logic [1:0]  mode_req = 2'd0, dgam_sel = 2'd0;
    logic [9:0]  pix_r = '0, pix_g = '0, pix_b = '0;
    logic [2:0]  status;
    logic        out_vld;
    logic [11:0] out_r, out_g, out_b;

    int total = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    igam_dual_bank_lut u0 (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .idx_wr(idx_wr), .idx_val(idx_val),
        .data_wr(data_wr), .data_val(data_val), .wr_mask(wr_mask), .mem_pwr_en(mem_pwr_en),
        .mode_req(mode_req), .dgam_sel(dgam_sel), .frame_start(frame_start), .status(status),
        .pix_vld(pix_vld), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_vld(out_vld), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    function automatic logic [11:0] fa(int i, int c);
        return 12'((i * 13 + c * 700 + 7) % 4096);
    endfunction
    function automatic logic [11:0] fb(int i, int c);
        return 12'((4095 - i * 11 - c * 300) & 4095);
    endfunction
    function automatic logic [11:0] expect_ch(logic [1:0] m, logic [9:0] x, int c);
        logic [7:0] v;
        v = x[9:2];
        if (m == 2'd2) return fa(int'(v), c);
        if (m == 2'd3) return fb(int'(v), c);
        return {v, v[7:4]};
    endfunction

    task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_idx(logic [7:0] v);
        @(negedge clk); idx_wr = 1'b1; idx_val = v;
        @(negedge clk); idx_wr = 1'b0;
    endtask
    task automatic wr_data(logic [11:0] v);
        @(negedge clk); data_wr = 1'b1; data_val = v;
        @(negedge clk); data_wr = 1'b0;
    endtask
    task automatic apply_mode(logic [1:0] m);
        @(negedge clk); mode_req = m; frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask
    task automatic look(logic [9:0] r, logic [9:0] g, logic [9:0] b, output logic [35:0] res);
        @(negedge clk); pix_r = r; pix_g = g; pix_b = b; pix_vld = 1'b1;
        @(negedge clk); pix_vld = 1'b0;
        res = {out_r, out_g, out_b};
    endtask
    task automatic fill(logic b);
        bank_sel = b;
        wr_idx(8'd0);
        for (int i = 0; i < 256; i++)
            for (int c = 0; c < 3; c++)
                wr_data(b ? fb(i, c) : fa(i, c));
    endtask

    // Vector table: {mode, r, g, b}
    localparam int NV = 10;
    localparam logic [31:0] VEC [NV] = '{
        {2'd0, 10'd0,    10'd1023, 10'd517},
        {2'd1, 10'd4,    10'd803,  10'd255},
        {2'd2, 10'd0,    10'd1,    10'd2},
        {2'd2, 10'd1023, 10'd512,  10'd3},
        {2'd2, 10'd400,  10'd401,  10'd402},
        {2'd3, 10'd0,    10'd1020, 10'd1023},
        {2'd3, 10'd77,   10'd600,  10'd999},
        {2'd2, 10'd222,  10'd333,  10'd444},
        {2'd3, 10'd5,    10'd6,    10'd7},
        {2'd0, 10'd1000, 10'd20,   10'd300}
    };

    initial begin
        logic [35:0] res;
        logic [1:0]  m;
        logic [9:0]  r, g, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 outputs", {out_r, out_g, out_b}, 36'd0);
        chk("R1 vld/status", {32'd0, out_vld, status}, 36'd0);

        mem_pwr_en = 1'b1; wr_mask = 3'd7;
        fill(1'b0);   // R7: bank A
        fill(1'b1);   // R7: bank B

        // R2 R3 R7 R8 R11: table walk
        for (int k = 0; k < NV; k++) begin
            {m, r, g, b} = VEC[k];
            apply_mode(m);
            look(r, g, b, res);
            chk("R2/R3/R8/R11 table", res,
                {expect_ch(m, r, 0), expect_ch(m, g, 1), expect_ch(m, b, 2)});
            chk("R11 out_vld", {35'd0, out_vld}, 36'd1);
        end
        @(negedge clk);
        chk("R11 out_vld low", {35'd0, out_vld}, 36'd0);

        // R5: masked writes still rotate; R4: index auto-advance after blue
        apply_mode(2'd2);
        bank_sel = 1'b0; wr_mask = 3'b010;
        wr_idx(8'd5);
        wr_data(12'hA11); wr_data(12'hB22); wr_data(12'hC33);
        wr_mask = 3'b111;
        wr_data(12'hD44);
        look(10'd20, 10'd21, 10'd22, res);
        chk("R5 mask", res, {fa(5, 0), 12'hB22, fa(5, 2)});
        look(10'd24, 10'd25, 10'd26, res);
        chk("R4 advance", res, {12'hD44, fa(6, 1), fa(6, 2)});

        // R4: wrap 255 -> 0 after blue
        wr_idx(8'd255);
        wr_data(12'h001); wr_data(12'h002); wr_data(12'h003); wr_data(12'h004);
        look(10'd1023, 10'd0, 10'd0, res);
        chk("R4 wrap", res, {12'h001, fa(0, 1), fa(0, 2)});
        chk("R4 wrap hi", {24'd0, out_g}, {24'd0, fa(0, 1)});
        look(10'd1020, 10'd1022, 10'd1021, res);
        chk("R4 wrap high entry", res, {12'h001, 12'h002, 12'h003});

        // R4: index write beats a same-cycle data write
        wr_idx(8'd30);
        @(negedge clk); idx_wr = 1'b1; idx_val = 8'd31; data_wr = 1'b1; data_val = 12'hEEE;
        @(negedge clk); idx_wr = 1'b0; data_wr = 1'b0;
        look(10'd120, 10'd124, 10'd124, res);
        chk("R4 idx priority", res, {fa(30, 0), fa(31, 1), fa(31, 2)});

        // R6: unpowered writes ignored, index write still taken
        apply_mode(2'd3);
        bank_sel = 1'b1; mem_pwr_en = 1'b0;
        wr_idx(8'd20);
        wr_data(12'h111);
        mem_pwr_en = 1'b1;
        wr_data(12'h222);
        look(10'd80, 10'd81, 10'd82, res);
        chk("R6 power gate", res, {12'h222, fb(20, 1), fb(20, 2)});

        // R9: mode change held until frame_start; R10 status
        apply_mode(2'd2);
        @(negedge clk); mode_req = 2'd3;
        repeat (3) @(negedge clk);
        chk("R9 status held", {33'd0, status}, 36'd1);
        look(10'd36, 10'd36, 10'd36, res);
        chk("R9 still bank A", res, {fa(9, 0), fa(9, 1), fa(9, 2)});
        apply_mode(2'd3);
        chk("R9 status switched", {33'd0, status}, 36'd2);
        look(10'd36, 10'd36, 10'd36, res);
        chk("R9 bank B", res, {fb(9, 0), fb(9, 1), fb(9, 2)});

        // R10: combined status codes
        dgam_sel = 2'd1; @(negedge clk);
        chk("R10 B+romA", {33'd0, status}, 36'd5);
        dgam_sel = 2'd2; @(negedge clk);
        chk("R10 B+romB", {33'd0, status}, 36'd6);
        apply_mode(2'd2);
        chk("R10 A+romB", {33'd0, status}, 36'd4);
        dgam_sel = 2'd1; @(negedge clk);
        chk("R10 A+romA", {33'd0, status}, 36'd3);
        dgam_sel = 2'd3; @(negedge clk);
        chk("R10 A+rom3", {33'd0, status}, 36'd1);
        apply_mode(2'd1);
        chk("R10 pass", {33'd0, status}, 36'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule